// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock for an I2C controller from a fast system clock. Scaling happens in two stages. A base-tick stage turns the system clock into a slower strobe. A phase stage then counts those strobes to shape the low and high halves of SCL. The phase stage reports every SCL transition on a one-cycle rise or fall strobe, so that a byte engine can time data changes and sampling from them.

The base tick is picked by a 4-bit selector:

- Selector 0 ticks on every cycle.
- Selectors 1 to 4 each read one byte N of a 32-bit prescale word and tick on average every (N+2)/2 cycles. A phase accumulator produces this, so an odd N gives alternating tick spacing.
- Higher selectors halve the selector-4 rate once per step.

A target may hold SCL low to stretch the clock. The high-phase count waits until the sampled line (already synchronised by the caller) really reads high.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, scl_o is 1 and base_tick, scl_rise and scl_fall are 0.
- R2: With base_sel = 0 and enable high, base_tick is 1 on every cycle.
- R3: With base_sel = s in 1..4, the prescale byte used is N = prescale_word[8*s-1 : 8*(s-1)]. Over the first k enabled cycles, exactly floor(2k/(N+2)) base ticks occur.
- R4: With base_sel = s > 4, the tick count over the first k enabled cycles is floor(floor(2k/(N3+2)) / 2^(s-4)), where N3 is prescale_word[31:24].
- R5: Each low phase of scl_o spans exactly lo_cnt+1 base ticks.
- R6: Each high phase spans exactly max(hi_cnt, min_hi_cnt)+1 base ticks that arrive while scl_in is high.
- R7: While scl_o is high but scl_in reads low, scl_o stays high and the high-phase count does not advance. With base_sel = 0, a stretch of S cycles lengthens the high phase by exactly S cycles.
- R8: scl_rise is 1 exactly in the cycle in which scl_o has just gone from 0 to 1. scl_fall is 1 exactly in the cycle in which scl_o has just gone from 1 to 0. The two are never 1 together.
- R9: While en is low, scl_o is 1, base_tick is 0 and no fall strobe occurs. On the first edge with en high, scl_o drops to 0 and a fall strobe starts a new low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low idles the generator with SCL released |
| base_sel | input | 4 | Base-tick selector |
| prescale_word | input | 32 | Four prescale bytes N, byte 0 for selector 1 |
| lo_cnt | input | 4 | Low phase length minus one, in base ticks |
| hi_cnt | input | 4 | High phase length minus one, in base ticks |
| min_hi_cnt | input | 4 | Floor for the high count |
| scl_in | input | 1 | Sampled SCL line level |
| base_tick | output | 1 | Registered base-tick strobe |
| scl_o | output | 1 | Generated SCL level (1 = released) |
| scl_rise | output | 1 | Strobe on an SCL rising transition |
| scl_fall | output | 1 | Strobe on an SCL falling transition |

## Verification
The bench uses the default parameters: four prescale bytes of eight bits and 4-bit selector and phase counts. With these values every selector up to 15 is reachable, and the longest halving (2048 prescaled ticks) fits within a short window when N3 is 0. Random selectors up to 6, small prescale bytes and random phase counts keep each phase within a few hundred cycles. Under those settings, odd-N alternating spacing, min-high overriding hi_cnt, and zero counts all occur many times per run.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;
endpackage

// File: rtl/scl_base_tick.sv
module scl_base_tick #(
  parameter int IDX_W   = 4,
  parameter int PRE_NUM = 4,
  parameter int BYTE_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic [IDX_W-1:0]          idx,
  input  logic [PRE_NUM*BYTE_W-1:0] div_word,
  output logic                      tick_o
);
  localparam int ACC_W  = BYTE_W + 1;
  localparam int SEL_W  = (PRE_NUM > 1) ? $clog2(PRE_NUM) : 1;
  localparam int HALF_W = (1 << IDX_W) - 1 - PRE_NUM;
  localparam logic [IDX_W-1:0] PRE_IDX = IDX_W'(PRE_NUM);

  logic [BYTE_W-1:0] pre_n [PRE_NUM];

  genvar gi;
  generate
    for (gi = 0; gi < PRE_NUM; gi++) begin : g_bytes
      assign pre_n[gi] = div_word[gi*BYTE_W +: BYTE_W];
    end
  endgenerate

  logic [SEL_W-1:0]  sel;
  logic [ACC_W-1:0]  acc, acc_sum, modulus, acc_nx;
  logic              pre_tick;
  logic [IDX_W-1:0]  shift;
  logic [HALF_W:0]   one_sh;
  logic [HALF_W-1:0] limit, hcnt;
  logic              half_tick, tick_nx, halving;

  always_comb begin
    halving   = idx > PRE_IDX;
    sel       = halving ? SEL_W'(PRE_NUM - 1) : SEL_W'(idx - 1'b1);
    modulus   = {1'b0, pre_n[sel]} + ACC_W'(2);
    acc_sum   = acc + ACC_W'(2);
    pre_tick  = acc_sum >= modulus;
    acc_nx    = pre_tick ? acc_sum - modulus : acc_sum;
    shift     = halving ? idx - PRE_IDX : '0;
    one_sh    = (HALF_W+1)'(1) << shift;
    limit     = HALF_W'(one_sh - 1'b1);
    half_tick = pre_tick && (hcnt == limit);
    if (idx == '0)    tick_nx = 1'b1;
    else if (halving) tick_nx = half_tick;
    else              tick_nx = pre_tick;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      acc    <= '0;
      hcnt   <= '0;
      tick_o <= 1'b0;
    end else begin
      acc    <= acc_nx;
      tick_o <= tick_nx;
      if (halving && pre_tick)
        hcnt <= (hcnt == limit) ? '0 : hcnt + 1'b1;
    end
  end

  a_r9_no_tick_when_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> !tick_o);
  a_r2_raw_clock_ticks: assert property (@(posedge clk) disable iff (rst)
    (en && idx == '0) |=> tick_o);
  a_r3_no_back_to_back_slow: assert property (@(posedge clk) disable iff (rst)
    (en && idx == PRE_IDX && $stable(idx) && pre_n[PRE_NUM-1] >= BYTE_W'(2) && tick_o)
      |=> !tick_o);
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             scl_in,
  input  logic [CNT_W-1:0] lo_cnt,
  input  logic [CNT_W-1:0] hi_cnt,
  input  logic [CNT_W-1:0] min_hi,
  output logic             scl_o,
  output logic             rise_o,
  output logic             fall_o
);
  scl_phase_e       st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] hi_lim;

  assign hi_lim = (hi_cnt > min_hi) ? hi_cnt : min_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= PH_IDLE;
      cnt    <= '0;
      scl_o  <= 1'b1;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (!en) begin
        st    <= PH_IDLE;
        cnt   <= '0;
        scl_o <= 1'b1;
        if (!scl_o) rise_o <= 1'b1;
      end else begin
        case (st)
          PH_IDLE: begin
            st     <= PH_LOW;
            cnt    <= '0;
            scl_o  <= 1'b0;
            fall_o <= 1'b1;
          end
          PH_LOW: if (tick) begin
            if (cnt == lo_cnt) begin
              st     <= PH_HIGH;
              cnt    <= '0;
              scl_o  <= 1'b1;
              rise_o <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_HIGH: if (tick && scl_in) begin
            if (cnt == hi_lim) begin
              st     <= PH_LOW;
              cnt    <= '0;
              scl_o  <= 1'b0;
              fall_o <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: begin
            st    <= PH_IDLE;
            scl_o <= 1'b1;
          end
        endcase
      end
    end
  end

  a_r8_rise_marks_edge: assert property (@(posedge clk) disable iff (rst)
    rise_o |-> (scl_o && !$past(scl_o)));
  a_r8_fall_marks_edge: assert property (@(posedge clk) disable iff (rst)
    fall_o |-> (!scl_o && $past(scl_o)));
  a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rise_o && fall_o));
  a_r9_idle_released: assert property (@(posedge clk) disable iff (rst)
    !en |=> (scl_o && !fall_o));
  a_r7_stretch_holds_high: assert property (@(posedge clk) disable iff (rst)
    (en && st == PH_HIGH && !scl_in) |=> (scl_o && $stable(cnt)));
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int IDX_W   = 4,
  parameter int PRE_NUM = 4,
  parameter int BYTE_W  = 8,
  parameter int CNT_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic [IDX_W-1:0]          base_sel,
  input  logic [PRE_NUM*BYTE_W-1:0] prescale_word,
  input  logic [CNT_W-1:0]          lo_cnt,
  input  logic [CNT_W-1:0]          hi_cnt,
  input  logic [CNT_W-1:0]          min_hi_cnt,
  input  logic                      scl_in,
  output logic                      base_tick,
  output logic                      scl_o,
  output logic                      scl_rise,
  output logic                      scl_fall
);
  scl_base_tick #(
    .IDX_W(IDX_W), .PRE_NUM(PRE_NUM), .BYTE_W(BYTE_W)
  ) u_tick (
    .clk(clk), .rst(rst), .en(en), .idx(base_sel),
    .div_word(prescale_word), .tick_o(base_tick)
  );

  scl_phase_fsm #(.CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst(rst), .en(en), .tick(base_tick), .scl_in(scl_in),
    .lo_cnt(lo_cnt), .hi_cnt(hi_cnt), .min_hi(min_hi_cnt),
    .scl_o(scl_o), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  a_r1_reset_released: assert property (@(posedge clk)
    $past(rst) |-> (scl_o && !scl_rise && !scl_fall && !base_tick));
endmodule

// File: tb/scl_timing_gen_bench.sv
module scl_timing_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [3:0]  base_sel = '0;
  logic [31:0] prescale_word = '0;
  logic [3:0]  lo_cnt = '0, hi_cnt = '0, min_hi_cnt = '0;
  logic        hold = 1'b0;
  logic        scl_line;
  logic        base_tick, scl_o, scl_rise, scl_fall;
  int          total = 0;
  int          bad = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  assign scl_line = scl_o & ~hold;

  scl_timing_gen u_scl_timing_gen (
    .clk(clk), .rst(rst), .en(en), .base_sel(base_sel),
    .prescale_word(prescale_word), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt),
    .min_hi_cnt(min_hi_cnt), .scl_in(scl_line), .base_tick(base_tick),
    .scl_o(scl_o), .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_ticks(input int idx, input logic [31:0] w, input int k);
    int n, p;
    if (idx == 0) return k;
    n = (idx <= 4) ? int'(w[8*(idx-1) +: 8]) : int'(w[31:24]);
    p = (2 * k) / (n + 2);
    if (idx <= 4) return p;
    return p >> (idx - 4);
  endfunction

  task automatic restart(input int idx, input logic [31:0] w,
                         input int l, input int h, input int m);
    @(negedge clk) en = 1'b0;
    repeat (2) @(negedge clk);
    base_sel = 4'(idx); prescale_word = w;
    lo_cnt = 4'(l); hi_cnt = 4'(h); min_hi_cnt = 4'(m);
    en = 1'b1;
  endtask

  // R2 / R3 / R4: tick count over a window of k enabled cycles
  task automatic tick_window(input int idx, input logic [31:0] w, input int k, input string req);
    int c = 0;
    restart(idx, w, 15, 15, 0);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      c += int'(base_tick);
    end
    check(c == exp_ticks(idx, w, k), req, c, exp_ticks(idx, w, k));
  endtask

  // R5 / R6 / R8: per-phase tick counts and strobe alignment
  task automatic phase_run(input int idx, input logic [31:0] w,
                           input int l, input int h, input int m, input int nph);
    int  c = 0, done = 0, guard = 0, hexp;
    bit  prev = 1'b1, started = 1'b0;
    hexp = ((h > m) ? h : m) + 1;
    restart(idx, w, l, h, m);
    while (done < nph && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (scl_rise != (scl_o && !prev) || scl_fall != (!scl_o && prev))
        check(1'b0, "R8 strobe alignment", int'({scl_rise, scl_fall}), int'({scl_o && !prev, !scl_o && prev}));
      if (scl_o != prev) begin
        if (started) begin
          if (prev) check(c == hexp, "R6 high phase ticks", c, hexp);
          else      check(c == l + 1, "R5 low phase ticks", c, l + 1);
          done++;
        end
        started = 1'b1;
        c = 0;
        prev = scl_o;
      end
      c += int'(base_tick);
    end
    check(done == nph, "R5 phases completed", done, nph);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(scl_o == 1'b1, "R1 scl released", int'(scl_o), 1);
    check(!scl_rise && !scl_fall, "R1 strobes quiet", int'({scl_rise, scl_fall}), 0);
    check(base_tick == 1'b0, "R1 tick quiet", int'(base_tick), 0);

    tick_window(0, 32'h0, 40, "R2 raw clock ticks");
    tick_window(1, 32'h0000_0001, 61, "R3 byte0 odd N");
    tick_window(2, 32'h0000_0600, 50, "R3 byte1 N=6");
    tick_window(3, 32'h00FF_0000, 700, "R3 byte2 N=255");
    tick_window(4, 32'h0300_0000, 77, "R3 byte3 N=3");
    tick_window(5, 32'h0100_0000, 91, "R4 one halving");
    tick_window(15, 32'h0000_0000, 4100, "R4 deepest halving");
    for (int i = 0; i < 6; i++) begin
      int idx = int'($urandom_range(0, 8));
      logic [31:0] w = $urandom & 32'h0F0F_0F0F;
      tick_window(idx, w, int'($urandom_range(20, 300)), "R4 random selector window");
    end

    // directed phase corners
    phase_run(0, 32'h0, 0, 0, 0, 6);
    phase_run(0, 32'h0, 15, 15, 0, 4);
    phase_run(1, 32'h0000_0003, 2, 1, 5, 6);   // R6 minimum-high overrides
    phase_run(5, 32'h0100_0000, 1, 2, 0, 4);
    for (int i = 0; i < 8; i++) begin
      phase_run(int'($urandom_range(0, 6)), $urandom & 32'h0303_0303,
                int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
                int'($urandom_range(0, 15)), 4);
    end

    // R7 stretching at selector 0: lo=2, hi=3, stretch 5 cycles -> high 9 cycles
    begin
      int left = 0, hl = 0;
      bit seen_fall = 1'b0, in_high = 1'b0, bad_drop = 1'b0;
      restart(0, 32'h0, 2, 3, 0);
      for (int i = 0; i < 60 && !seen_fall; i++) begin
        @(negedge clk);
        if (scl_rise && !in_high) begin in_high = 1'b1; left = 5; hl = 0; end
        if (in_high) begin
          if (scl_fall) seen_fall = 1'b1;
          else begin
            hl++;
            if (left > 0 && !scl_o) bad_drop = 1'b1;
          end
        end
        hold = (left > 0);
        if (left > 0) left--;
      end
      hold = 1'b0;
      check(hl == 9, "R7 stretched high length", hl, 9);
      check(!bad_drop, "R7 scl held during stretch", int'(bad_drop), 0);
    end

    // R9 enable drop mid low phase, then restart
    begin
      bit ok = 1'b1;
      restart(0, 32'h0, 10, 10, 0);
      repeat (3) @(negedge clk);
      en = 1'b0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (!scl_o || base_tick || scl_fall) ok = 1'b0;
      end
      check(ok, "R9 idle while disabled", int'(ok), 1);
      en = 1'b1;
      @(negedge clk);
      check(!scl_o && scl_fall, "R9 restart with low phase", int'({scl_o, scl_fall}), 1);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule